// File: doc/BRIEF.md
# Idle Column Sequencer for a Four-Lane 8b/10b Transmit Path

This block sits between the elasticity buffer and the 8b/10b encoders on the transmit side of a four-lane retimer. Each cycle it reads one column, which holds one 9-bit word per lane (bit 8 is the control flag, bits 7:0 the byte). It hands the encoders one registered column of byte and control-flag pairs. Columns that hold data or ordinary control characters go through untouched. Columns recognised as idle are rebuilt according to the configured mode.

There are three idle modes. The first is a randomised mix of align (K28.3), sync (K28.5) and skip (K28.0) columns, with align columns spaced by a reloaded down-counter. The second turns every idle column into K28.5. The third repeats the first idle column of each gap, exactly as it was received. The rate-matching logic can raise an insert request. The block then emits one extra idle column and holds off the buffer read for that cycle, so elasticity only ever moves by whole idle columns.

Top module: `idle_akr_seq`

## Requirements
- R1: A column that is not idle and is not displaced by an insert request appears on the outputs one clock later, bit-exact. Lane i byte is `tx_data[8i+7:8i]` and its control flag is `tx_ctrl[i]`, both taken from `col_in[9i+8:0+9i]`, where bit 8 is the flag.
- R2: With translation active, a column is idle only when all four lanes equal `cfg_idle_word` (typically 0x107). With translation inactive, a column is idle only when every lane is one of 0x1BC, 0x17C or 0x11C.
- R3: With sequencing active, every idle column is output with the same byte on all lanes, every control flag set, and the byte one of 0x7C (align), 0xBC (sync) or 0x1C (skip).
- R4: Align columns are sent only for idle columns. In an unbroken run of idle columns, consecutive align columns are 17 to 32 columns apart.
- R5: Sequenced idle columns that are not align carry sync or skip. The choice follows the top bit of a 7-bit LFSR (x^7+x^6+1) that steps every cycle, and both characters occur.
- R6: The first idle column after a column that carries terminate (0x1FD on any lane) is never skip.
- R7: With translation active and sequencing inactive, every idle column is output as 0x1BC on all lanes.
- R8: With both translation and sequencing inactive, the first idle column of a gap is output as received. Every later idle column of that gap, inserted ones included, repeats it.
- R9: `cfg_link_en` turns on translation and sequencing whatever the other two enables are set to.
- R10: While `ins_idle` is high, `rd_en` is low in the same cycle and the next output column is idle for the current mode. The column held at the input appears once the request drops.
- R11: During reset the outputs show 0x1BC on all lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Column clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_seq_en | input | 1 | Enable randomised align/sync/skip idle generation |
| cfg_xlate_en | input | 1 | Detect idle as the internal idle word |
| cfg_link_en | input | 1 | Forces both sequencing and translation |
| cfg_idle_word | input | 9 | Internal idle word to detect |
| col_in | input | 36 | Column from the buffer, 9 bits per lane, lane 0 lowest |
| ins_idle | input | 1 | Request to insert one idle column |
| rd_en | output | 1 | Consume the column at `col_in` this cycle |
| tx_data | output | 32 | Byte per lane to the encoders |
| tx_ctrl | output | 4 | Control flag per lane |

## Verification
The hardest situation to reach from the ports is a terminate column followed at once by an idle column, at an LFSR phase where the generator would otherwise pick skip. The bench repeats the terminate-then-idle pattern hundreds of times. Between repeats it varies the number of idle and data columns, so that the arrival lands on many LFSR phases. Align spacing is measured only over long unbroken idle runs, where the bound is exact. Runs broken by data columns check only that align never lands on data.

// File: rtl/akr_pkg.sv
package akr_pkg;
  localparam int LANE_W = 9;
  localparam int LFSR_W = 7;
  localparam int GAP_W  = 5;

  localparam logic [7:0] K_SYNC  = 8'hBC;
  localparam logic [7:0] K_ALIGN = 8'h7C;
  localparam logic [7:0] K_SKIP  = 8'h1C;
  localparam logic [7:0] K_TERM  = 8'hFD;

  typedef enum logic [1:0] {IDL_K = 2'd0, IDL_A = 2'd1, IDL_R = 2'd2} idle_sel_e;

  // x^7 + x^6 + 1, shifting toward the MSB
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[6] ^ s[5]};
  endfunction

  // align gap reload: 16 + low nibble of the LFSR, range 16..31
  function automatic logic [GAP_W-1:0] gap_reload(input logic [LFSR_W-1:0] s);
    return {1'b1, s[3:0]};
  endfunction

  function automatic logic [7:0] idle_byte(input idle_sel_e s);
    case (s)
      IDL_A:   return K_ALIGN;
      IDL_R:   return K_SKIP;
      default: return K_SYNC;
    endcase
  endfunction

  function automatic logic is_idle_code(input logic [LANE_W-1:0] w);
    return (w == {1'b1, K_SYNC}) || (w == {1'b1, K_ALIGN}) || (w == {1'b1, K_SKIP});
  endfunction
endpackage

// File: rtl/akr_col_scan.sv
module akr_col_scan #(
  parameter int LANES = 4
) (
  input  logic [LANES*akr_pkg::LANE_W-1:0] col,
  input  logic [akr_pkg::LANE_W-1:0]       word,
  output logic                             all_word,
  output logic                             all_code,
  output logic                             any_term
);
  localparam int W = akr_pkg::LANE_W;
  logic [LANES-1:0] hit_w, hit_c, hit_t;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign hit_w[g] = (col[g*W +: W] == word);
    assign hit_c[g] = akr_pkg::is_idle_code(col[g*W +: W]);
    assign hit_t[g] = (col[g*W +: W] == {1'b1, akr_pkg::K_TERM});
  end

  assign all_word = &hit_w;
  assign all_code = &hit_c;
  assign any_term = |hit_t;
endmodule

// File: rtl/akr_gen.sv
module akr_gen (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                idle_col,
  input  logic                term_col,
  output akr_pkg::idle_sel_e  sel
);
  import akr_pkg::*;

  logic [LFSR_W-1:0] lfsr_q;
  logic [GAP_W-1:0]  gap_q;
  logic              term_pend_q;
  logic              align_due;

  assign align_due = (gap_q == '0);

  always_comb begin
    if (align_due)                      sel = IDL_A;
    else if (lfsr_q[6] && !term_pend_q) sel = IDL_R;
    else                                sel = IDL_K;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lfsr_q      <= '1;
      gap_q       <= '0;
      term_pend_q <= 1'b0;
    end else begin
      lfsr_q <= lfsr_step(lfsr_q);
      if (idle_col && align_due)  gap_q <= gap_reload(lfsr_q);
      else if (!align_due)        gap_q <= gap_q - 1'b1;
      if (term_col)               term_pend_q <= 1'b1;
      else if (idle_col)          term_pend_q <= 1'b0;
    end
  end

  // R4: after an align column the gap counter restarts at 16 or more
  a_r4_gap_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_col && sel == IDL_A) |=> (gap_q >= 5'd16));
  // R4: an expired counter waits for an idle column
  a_r4_wait_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_col && gap_q == '0) |=> (gap_q == '0));
endmodule

// File: rtl/idle_akr_seq.sv
module idle_akr_seq #(
  parameter int LANES = 4
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             cfg_seq_en,
  input  logic                             cfg_xlate_en,
  input  logic                             cfg_link_en,
  input  logic [8:0]                       cfg_idle_word,
  input  logic [LANES*9-1:0]               col_in,
  input  logic                             ins_idle,
  output logic                             rd_en,
  output logic [LANES*8-1:0]               tx_data,
  output logic [LANES-1:0]                 tx_ctrl
);
  import akr_pkg::*;
  localparam int COL_W = LANES * LANE_W;
  localparam logic [COL_W-1:0] SYNC_COL = {LANES{{1'b1, K_SYNC}}};

  logic seq_on, xl_on;
  logic all_word, all_code, any_term;
  logic in_idle, eff_idle;
  idle_sel_e sel;
  logic [COL_W-1:0] nxt_col, out_q, held_q;
  logic gap_q, out_seq_idle_q, out_term;

  // R9: link enable forces both features
  assign seq_on = cfg_seq_en | cfg_link_en;
  assign xl_on  = cfg_xlate_en | cfg_link_en;

  akr_col_scan #(.LANES(LANES)) i_scan (
    .col(col_in), .word(cfg_idle_word),
    .all_word(all_word), .all_code(all_code), .any_term(any_term)
  );

  assign in_idle  = xl_on ? all_word : all_code;
  assign eff_idle = ins_idle | in_idle;
  assign rd_en    = !ins_idle;

  akr_gen i_gen (
    .clk(clk), .rst_n(rst_n),
    .idle_col(eff_idle & seq_on),
    .term_col(any_term & !ins_idle),
    .sel(sel)
  );

  always_comb begin
    if (!eff_idle)              nxt_col = col_in;
    else if (seq_on)            nxt_col = {LANES{{1'b1, idle_byte(sel)}}};
    else if (xl_on)             nxt_col = SYNC_COL;
    else if (ins_idle || gap_q) nxt_col = held_q;
    else                        nxt_col = col_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_q          <= SYNC_COL;
      held_q         <= SYNC_COL;
      gap_q          <= 1'b0;
      out_seq_idle_q <= 1'b0;
    end else begin
      out_q          <= nxt_col;
      gap_q          <= eff_idle;
      out_seq_idle_q <= eff_idle & seq_on;
      if (!seq_on && !xl_on && in_idle && !ins_idle && !gap_q)
        held_q <= col_in;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_out
    assign tx_data[g*8 +: 8] = out_q[g*LANE_W +: 8];
    assign tx_ctrl[g]        = out_q[g*LANE_W + 8];
  end

  always_comb begin
    out_term = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (out_q[i*LANE_W +: LANE_W] == {1'b1, K_TERM}) out_term = 1'b1;
  end

  a_r1_data_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_idle && !in_idle) |=> (out_q == $past(col_in)));
  a_r3_lanes_match: assert property (@(posedge clk) disable iff (!rst_n)
    out_seq_idle_q |-> ((out_q == {LANES{out_q[8:0]}}) && out_q[8] &&
      (out_q[7:0] == K_SYNC || out_q[7:0] == K_ALIGN || out_q[7:0] == K_SKIP)));
  a_r6_no_skip_after_t: assert property (@(posedge clk) disable iff (!rst_n)
    (out_seq_idle_q && $past(out_term)) |-> (out_q[7:0] != K_SKIP));
  a_r10_insert_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_idle && seq_on) |=> out_seq_idle_q);
endmodule

// File: tb/test_idle_akr_seq.sv
module test_idle_akr_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_seq_en = 0, cfg_xlate_en = 0, cfg_link_en = 0;
  logic [8:0] cfg_idle_word = 9'h107;
  logic [35:0] col_in = '0;
  logic ins_idle = 0, rd_en;
  logic [31:0] tx_data;
  logic [3:0] tx_ctrl;
  logic [35:0] got;
  logic rd_seen;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  idle_akr_seq i_idle_akr_seq (
    .clk(clk), .rst_n(rst_n), .cfg_seq_en(cfg_seq_en), .cfg_xlate_en(cfg_xlate_en),
    .cfg_link_en(cfg_link_en), .cfg_idle_word(cfg_idle_word), .col_in(col_in),
    .ins_idle(ins_idle), .rd_en(rd_en), .tx_data(tx_data), .tx_ctrl(tx_ctrl)
  );

  always_comb
    for (int i = 0; i < 4; i++) got[i*9 +: 9] = {tx_ctrl[i], tx_data[i*8 +: 8]};

  function automatic logic [35:0] rep(input logic [8:0] w);
    return {w, w, w, w};
  endfunction

  function automatic logic [35:0] mk_data(input int k);
    logic [7:0] a, b, c, d;
    a = 8'(k); b = 8'(k * 37); c = 8'(k * 91 + 3); d = 8'(k) ^ 8'h5A;
    return {k[1], d, 1'b0, c, k[0], b, 1'b0, a};
  endfunction

  function automatic bit seq_idle_ok(input logic [35:0] c);
    return (c == rep(c[8:0])) && (c[8:0] == 9'h1BC || c[8:0] == 9'h17C || c[8:0] == 9'h11C);
  endfunction

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_bit(input string req, input bit ok, input logic [35:0] act);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=condition true", req, act);
    end
  endtask

  task automatic step(input logic [35:0] c, input logic ins);
    col_in = c; ins_idle = ins;
    #1 rd_seen = rd_en;
    @(posedge clk); #1;
  endtask

  task automatic set_mode(input logic s, input logic x, input logic l);
    cfg_seq_en = s; cfg_xlate_en = x; cfg_link_en = l;
  endtask

  // R3 R4 R5: long idle run, spacing and character set
  task automatic idle_run(input logic [35:0] c, input int n, input string tag);
    int last_a = -1, nk = 0, nr = 0;
    bit lanes_ok = 1, gap_ok = 1;
    logic [35:0] bad = '0;
    for (int k = 0; k < n; k++) begin
      step(c, 1'b0);
      if (!seq_idle_ok(got)) begin lanes_ok = 0; bad = got; end
      if (got[8:0] == 9'h17C) begin
        if (last_a >= 0 && (k - last_a < 17 || k - last_a > 32)) begin gap_ok = 0; bad = got; end
        last_a = k;
      end
      if (got[8:0] == 9'h1BC) nk++;
      if (got[8:0] == 9'h11C) nr++;
    end
    chk_bit({tag, " R3 all lanes same idle character"}, lanes_ok, bad);
    chk_bit({tag, " R4 align spacing 17..32"}, gap_ok && last_a >= 0, bad);
    chk_bit({tag, " R5 both sync and skip present"}, nk > 0 && nr > 0, 36'(nr));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R11 reset output", got, rep(9'h1BC));
    rst_n = 1'b1;

    // R1: pass-through in every mode combination
    for (int m = 0; m < 8; m++) begin
      bit ok = 1; logic [35:0] bad = '0, exp = '0;
      set_mode(m[0], m[1], m[2]);
      for (int k = 0; k < 40; k++) begin
        step(mk_data(k * 7 + m), 1'b0);
        if (got !== mk_data(k * 7 + m)) begin ok = 0; bad = got; exp = mk_data(k * 7 + m); end
      end
      chk_bit($sformatf("R1 data pass mode %0d exp %h", m, exp), ok, bad);
    end

    // R2 R3 R4 R5: sequencing without translation, raw idle codes
    set_mode(1, 0, 0);
    idle_run({9'h1BC, 9'h11C, 9'h17C, 9'h1BC}, 1500, "seq");
    // R9: link enable alone, internal idle word
    set_mode(0, 0, 1);
    idle_run(rep(9'h107), 600, "link R9");

    // R4: align never lands on data when idle is broken by data
    begin
      bit ok = 1; logic [35:0] bad = '0;
      set_mode(1, 0, 0);
      for (int k = 0; k < 400; k++) begin
        if (k % 5 == 0) begin
          step(mk_data(k), 1'b0);
          if (got !== mk_data(k)) begin ok = 0; bad = got; end
        end else begin
          step(rep(9'h1BC), 1'b0);
          if (!seq_idle_ok(got)) begin ok = 0; bad = got; end
        end
      end
      chk_bit("R4 mixed data and idle", ok, bad);
    end

    // R6: terminate then idle, many LFSR phases
    begin
      bit ok = 1; logic [35:0] bad = '0;
      set_mode(0, 0, 1);
      for (int t = 0; t < 400; t++) begin
        step(mk_data(t), 1'b0);
        step({9'h000, 9'h055, 9'h0AA, 9'h1FD}, 1'b0);
        step(rep(9'h107), 1'b0);
        if (got[8:0] == 9'h11C || !seq_idle_ok(got)) begin ok = 0; bad = got; end
        for (int j = 0; j < t % 4; j++) step(rep(9'h107), 1'b0);
      end
      chk_bit("R6 first idle after terminate not skip", ok, bad);
    end

    // R7 R2: translation only
    set_mode(0, 1, 0);
    step(rep(9'h107), 1'b0);
    chk("R7 idle word to sync", got, rep(9'h1BC));
    step({9'h033, 9'h107, 9'h107, 9'h107}, 1'b0);
    chk("R2 partial idle word passes", got, {9'h033, 9'h107, 9'h107, 9'h107});
    step(rep(9'h1BC), 1'b0);
    chk("R2 raw code not idle under translation", got, rep(9'h1BC));
    step(rep(9'h11C), 1'b0);
    chk("R2 raw skip passes under translation", got, rep(9'h11C));
    cfg_idle_word = 9'h1AA;
    step(rep(9'h1AA), 1'b0);
    chk("R2 programmed idle word", got, rep(9'h1BC));
    step(rep(9'h107), 1'b0);
    chk("R2 old idle word passes", got, rep(9'h107));
    cfg_idle_word = 9'h107;

    // R8: neither translation nor sequencing
    set_mode(0, 0, 0);
    step(mk_data(3), 1'b0);
    step({9'h17C, 9'h1BC, 9'h11C, 9'h1BC}, 1'b0);
    chk("R8 first gap column as received", got, {9'h17C, 9'h1BC, 9'h11C, 9'h1BC});
    for (int j = 0; j < 3; j++) begin
      step(rep(9'h1BC), 1'b0);
      chk("R8 gap repeats first column", got, {9'h17C, 9'h1BC, 9'h11C, 9'h1BC});
    end
    step(mk_data(9), 1'b1);
    chk("R8 R10 inserted column repeats first", got, {9'h17C, 9'h1BC, 9'h11C, 9'h1BC});
    step(mk_data(9), 1'b0);
    chk("R10 held data follows insert", got, mk_data(9));
    step(rep(9'h11C), 1'b0);
    chk("R8 new gap first column", got, rep(9'h11C));
    step(rep(9'h17C), 1'b0);
    chk("R8 new gap repeats", got, rep(9'h11C));

    // R10: insert under sequencing and translation
    set_mode(1, 0, 0);
    step(mk_data(21), 1'b1);
    chk_bit("R10 rd_en low during insert", !rd_seen, 36'(rd_seen));
    chk_bit("R10 inserted column is sequenced idle", seq_idle_ok(got), got);
    step(mk_data(21), 1'b0);
    chk_bit("R10 rd_en high without insert", rd_seen, 36'(rd_seen));
    chk("R10 held column appears after insert", got, mk_data(21));
    set_mode(0, 1, 0);
    step(mk_data(22), 1'b1);
    chk("R10 R7 inserted column is sync", got, rep(9'h1BC));
    step(mk_data(22), 1'b0);
    chk("R10 held column after translated insert", got, mk_data(22));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule